// File: doc/BRIEF.md
# Opcode-Fetch-Aware Wait State Generator

This block stretches memory cycles of an 8-bit CPU by raising a wait request for a short, fixed number of clock cycles. Software selects its behaviour by sending one byte to a fixed I/O port. One setting stretches every memory access: opcode fetches, operand reads and writes. A second setting stretches only instruction fetches. The remaining settings switch stretching off.

In fetch-only operation the block watches the opcode bytes it fetches. When the first byte of an instruction is one of the escape bytes CBh, DDh, EDh or FDh, the read that follows is also stretched. The next read after that is treated as an ordinary operand read or as the start of a new instruction. A turbo input doubles every stretch from one cycle to two.

The CPU side drives active-high strobes. An access is one continuous stretch of `memReq`, which stays high until the wait request has dropped.

Top module: `wsGen`

## Requirements
- R1: After reset `waitReq` is low and the mode register holds FFh, so no memory access is stretched until software writes a mode.
- R2: A cycle with `ioReq` and `wrStb` high and `portAddr` equal to BFh loads `dataIn` into the mode register. An I/O write to any other port leaves the mode unchanged.
- R3: With mode 00h every memory access is stretched: opcode fetches (`m1Stb` and `rdStb`), plain reads (`rdStb` only) and writes (`wrStb`).
- R4: With mode 04h an opcode fetch is stretched. Plain reads and writes are not stretched, except for the read covered by R5.
- R5: With mode 04h, when an opcode fetch returns CBh, DDh, EDh or FDh, the next memory read is stretched, whether or not `m1Stb` is high for it.
- R6: The escape tracking clears after that second read. With mode 04h, a following read without `m1Stb` is not stretched. A following fetch with `m1Stb` is stretched as a new instruction.
- R7: Any mode value other than 00h and 04h disables stretching of all accesses.
- R8: Each stretch lasts 1 cycle when `turboSel` is low and 2 cycles when it is high. `turboSel` is sampled in the first cycle of the access.
- R9: `waitReq` rises in the cycle after the first cycle in which `memReq` is seen high. It stays high for exactly the stretch length, in one unbroken run, and occurs once per access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rstN | input | 1 | Active-low synchronous reset |
| memReq | input | 1 | Memory access in progress |
| ioReq | input | 1 | I/O access in progress |
| rdStb | input | 1 | Access is a read |
| wrStb | input | 1 | Access is a write |
| m1Stb | input | 1 | Read is an opcode fetch |
| portAddr | input | 8 | Low byte of the I/O address |
| dataIn | input | 8 | CPU data bus (written byte or fetched opcode) |
| turboSel | input | 1 | Selects the doubled stretch length |
| waitReq | output | 1 | Wait request to the CPU |

## Verification
A corrupted mode register shows up on the very next memory access. Every kind of access is then stretched, or none is, or writes are stretched when they should not be. A stuck escape flag is only seen one access later, as a missing or extra wait on the read after an escape fetch. For that reason the sequences place plain reads directly after escape, non-escape and double-escape fetches. A counter that loads the wrong length or misses a decrement is seen within the same access as a run of the wrong length, or as a wait that outlives `memReq`.

// File: rtl/wsPkg.sv
package wsPkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 8;
  localparam int BASE_WAIT = 1;
  localparam int TURBO_WAIT = 2;
  localparam int CNT_W = $clog2(TURBO_WAIT + 1);
  localparam logic [ADDR_W-1:0] MODE_PORT = 8'hBF;
  localparam logic [DATA_W-1:0] MODE_ALL_CODE = 8'h00;
  localparam logic [DATA_W-1:0] MODE_FETCH_CODE = 8'h04;
  localparam logic [DATA_W-1:0] MODE_RESET = 8'hFF;
  localparam int NUM_PREFIX = 4;
  localparam logic [NUM_PREFIX-1:0][DATA_W-1:0] PREFIX_CODES =
    {8'hFD, 8'hED, 8'hDD, 8'hCB};

  typedef enum logic [1:0] {WS_OFF, WS_ALL, WS_FETCH} wsMode_e;

  typedef struct packed {
    logic modeWrite;
    logic opLatch;
    logic countLoad;
    logic [CNT_W-1:0] countLen;
  } wsStrobes_t;

  function automatic wsMode_e decodeMode(input logic [DATA_W-1:0] code);
    if (code == MODE_ALL_CODE) return WS_ALL;
    else if (code == MODE_FETCH_CODE) return WS_FETCH;
    else return WS_OFF;
  endfunction
endpackage

// File: rtl/wsData.sv
module wsData
  import wsPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  wsStrobes_t        strobes,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] modeReg,
  output logic [DATA_W-1:0] opcodeReg,
  output logic              waitReq
);
  logic [CNT_W-1:0] waitCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg <= MODE_RESET;
    end else if (strobes.modeWrite) begin
      modeReg <= dataIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opcodeReg <= '0;
    end else if (strobes.opLatch) begin
      opcodeReg <= dataIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitCnt <= '0;
    end else if (strobes.countLoad) begin
      waitCnt <= strobes.countLen;
    end else if (waitCnt != '0) begin
      waitCnt <= waitCnt - 1'b1;
    end
  end

  assign waitReq = (waitCnt != '0);
endmodule

// File: rtl/wsCtrl.sv
module wsCtrl
  import wsPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              memReq,
  input  logic              ioReq,
  input  logic              rdStb,
  input  logic              wrStb,
  input  logic              m1Stb,
  input  logic [ADDR_W-1:0] portAddr,
  input  logic              turboSel,
  input  logic [DATA_W-1:0] modeReg,
  input  logic [DATA_W-1:0] opcodeReg,
  input  logic              waitReq,
  output wsStrobes_t        strobes
);
  localparam logic [CNT_W-1:0] LEN_BASE = CNT_W'(BASE_WAIT);
  localparam logic [CNT_W-1:0] LEN_TURBO = CNT_W'(TURBO_WAIT);

  logic memReqPrev;
  logic prefixPending;
  logic curFetch;
  logic curRead;
  logic accessStart;
  logic accessEnd;
  logic isFetch;
  logic needWait;
  logic opIsPrefix;
  wsMode_e mode;
  logic [NUM_PREFIX-1:0] prefixHit;

  assign accessStart = memReq && !memReqPrev;
  assign accessEnd = !memReq && memReqPrev;
  assign isFetch = memReq && m1Stb && rdStb;
  assign mode = decodeMode(modeReg);

  for (genvar i = 0; i < NUM_PREFIX; i++) begin : gPrefix
    assign prefixHit[i] = (opcodeReg == PREFIX_CODES[i]);
  end
  assign opIsPrefix = |prefixHit;

  always_comb begin
    unique case (mode)
      WS_ALL:   needWait = 1'b1;
      WS_FETCH: needWait = isFetch || (prefixPending && rdStb);
      default:  needWait = 1'b0;
    endcase
  end

  always_comb begin
    strobes.modeWrite = ioReq && wrStb && (portAddr == MODE_PORT);
    strobes.opLatch = isFetch && !waitReq;
    strobes.countLoad = accessStart && needWait;
    strobes.countLen = turboSel ? LEN_TURBO : LEN_BASE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memReqPrev <= 1'b0;
      curFetch <= 1'b0;
      curRead <= 1'b0;
      prefixPending <= 1'b0;
    end else begin
      memReqPrev <= memReq;
      if (accessStart) begin
        curFetch <= isFetch;
        curRead <= rdStb;
      end
      if (accessEnd && curRead) begin
        prefixPending <= prefixPending ? 1'b0 : (curFetch && opIsPrefix);
      end
    end
  end
endmodule

// File: rtl/wsGen.sv
module wsGen
  import wsPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              memReq,
  input  logic              ioReq,
  input  logic              rdStb,
  input  logic              wrStb,
  input  logic              m1Stb,
  input  logic [ADDR_W-1:0] portAddr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              turboSel,
  output logic              waitReq
);
  wsStrobes_t strobes;
  logic [DATA_W-1:0] modeValue;
  logic [DATA_W-1:0] opcodeValue;

  wsCtrl uCtrl (
    .clk(clk), .rstN(rstN), .memReq(memReq), .ioReq(ioReq),
    .rdStb(rdStb), .wrStb(wrStb), .m1Stb(m1Stb), .portAddr(portAddr),
    .turboSel(turboSel), .modeReg(modeValue), .opcodeReg(opcodeValue),
    .waitReq(waitReq), .strobes(strobes)
  );

  wsData uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .dataIn(dataIn),
    .modeReg(modeValue), .opcodeReg(opcodeValue), .waitReq(waitReq)
  );
endmodule

// File: rtl/wsGenChecker.sv
module wsGenChecker
  import wsPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic              wrStb,
  input logic              turboSel,
  input logic              waitReq,
  input logic [DATA_W-1:0] modeValue
);
  a_r9_wait_inside_access: assert property (@(posedge clk) disable iff (!rstN)
    waitReq |-> memReq);

  a_r9_rise_after_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(waitReq) |-> ($past(memReq) && !$past(memReq, 2)));

  a_r9_no_long_run: assert property (@(posedge clk) disable iff (!rstN)
    (waitReq && $past(waitReq)) |=> !waitReq);

  a_r8_base_len: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(waitReq) && !$past(turboSel)) |=> !waitReq);

  a_r8_turbo_len: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(waitReq) && $past(turboSel)) |=> waitReq);

  a_r3_all_waited: assert property (@(posedge clk) disable iff (!rstN)
    (modeValue == MODE_ALL_CODE && memReq && !$past(memReq)) |=> waitReq);

  a_r4_write_unwaited: assert property (@(posedge clk) disable iff (!rstN)
    (modeValue == MODE_FETCH_CODE && memReq && !$past(memReq) && wrStb) |=> !waitReq);

  a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (modeValue != MODE_ALL_CODE && modeValue != MODE_FETCH_CODE &&
     memReq && !$past(memReq)) |=> !waitReq);
endmodule

bind wsGen wsGenChecker uChecker (
  .clk(clk), .rstN(rstN), .memReq(memReq), .wrStb(wrStb),
  .turboSel(turboSel), .waitReq(waitReq), .modeValue(modeValue)
);

// File: tb/tb_wsGen.sv
`timescale 1ns/1ps
module tb_wsGen;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic memReq = 1'b0, ioReq = 1'b0, rdStb = 1'b0, wrStb = 1'b0, m1Stb = 1'b0;
  logic [7:0] portAddr = '0, dataIn = '0;
  logic turboSel = 1'b0;
  logic waitReq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  int expQ[$];
  string tagQ[$];

  logic [7:0] modelMode = 8'hFF;
  bit modelPend = 0;

  always #2 clk = ~clk;

  wsGen dut (
    .clk(clk), .rstN(rstN), .memReq(memReq), .ioReq(ioReq), .rdStb(rdStb),
    .wrStb(wrStb), .m1Stb(m1Stb), .portAddr(portAddr), .dataIn(dataIn),
    .turboSel(turboSel), .waitReq(waitReq)
  );

  function automatic bit isEscape(input logic [7:0] b);
    return (b == 8'hCB) || (b == 8'hDD) || (b == 8'hED) || (b == 8'hFD);
  endfunction

  task automatic ioWrite(input logic [7:0] port, input logic [7:0] val);
    @(negedge clk);
    ioReq = 1; wrStb = 1; portAddr = port; dataIn = val;
    @(negedge clk);
    ioReq = 0; wrStb = 0;
    if (port == 8'hBF) modelMode = val;
  endtask

  // kind: 0 = opcode fetch, 1 = plain read, 2 = write
  task automatic memAccess(input int kind, input logic [7:0] val, input string tag);
    int exp;
    bit isRd;
    bit isM1;
    isRd = (kind != 2);
    isM1 = (kind == 0);
    exp = 0;
    if (modelMode == 8'h00) exp = 1;
    else if (modelMode == 8'h04 && ((isM1 && isRd) || (modelPend && isRd))) exp = 1;
    if (turboSel) exp = exp * 2;
    if (isRd) begin
      if (modelPend) modelPend = 0;
      else if (isM1 && isEscape(val)) modelPend = 1;
    end
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    memReq = 1; rdStb = isRd; wrStb = !isRd; m1Stb = isM1; dataIn = val;
    repeat (4) @(negedge clk);
    memReq = 0; rdStb = 0; wrStb = 0; m1Stb = 0;
    @(negedge clk);
  endtask

  // Monitor: count wait cycles per access and compare with the scoreboard
  initial begin
    bit inAcc;
    bit firstHigh;
    int cnt;
    int exp;
    string tag;
    inAcc = 0; cnt = 0; firstHigh = 0;
    forever begin
      @(posedge clk);
      #1;
      if (rstN) begin
        if (memReq) begin
          if (!inAcc) begin
            inAcc = 1; cnt = 0; firstHigh = waitReq;
          end
          if (waitReq) cnt++;
        end else if (inAcc) begin
          inAcc = 0;
          exp = expQ.pop_front();
          tag = tagQ.pop_front();
          checks++;
          if (cnt != exp) begin
            errors++;
            $display("FAIL %s: wait cycles actual=%0d expected=%0d", tag, cnt, exp);
          end
          if (exp > 0) begin
            checks++;
            if (!firstHigh) begin
              errors++;
              $display("FAIL R9 (%s): wait start actual=late expected=first cycle", tag);
            end
          end
        end else if (waitReq) begin
          checks++; errors++;
          $display("FAIL R9: waitReq outside access actual=1 expected=0");
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    checks++;
    if (waitReq !== 1'b0) begin
      errors++;
      $display("FAIL R1: waitReq after reset actual=%b expected=0", waitReq);
    end
    memAccess(0, 8'h3E, "R1 fetch after reset");
    memAccess(2, 8'h11, "R1 write after reset");

    ioWrite(8'hBE, 8'h00);
    memAccess(0, 8'h3E, "R2 other port ignored");

    ioWrite(8'hBF, 8'h00);
    memAccess(0, 8'h3E, "R3 fetch");
    memAccess(1, 8'h55, "R3 read");
    memAccess(2, 8'hAA, "R3 write");
    turboSel = 1;
    memAccess(0, 8'h3E, "R8 turbo fetch all");
    memAccess(2, 8'hAA, "R8 turbo write all");
    turboSel = 0;

    ioWrite(8'hBF, 8'h04);
    memAccess(0, 8'h3E, "R4 fetch");
    memAccess(1, 8'h12, "R4 operand read");
    memAccess(2, 8'h34, "R4 write");
    memAccess(0, 8'hCB, "R5 fetch CB");
    memAccess(1, 8'h46, "R5 second byte after CB");
    memAccess(1, 8'h00, "R6 read after pair");
    memAccess(0, 8'hDD, "R5 fetch DD");
    memAccess(0, 8'h21, "R5 second fetch after DD");
    memAccess(1, 8'h00, "R6 operand after DD pair");
    memAccess(0, 8'hFD, "R5 fetch FD");
    memAccess(0, 8'hFD, "R6 FD as second byte");
    memAccess(1, 8'h07, "R6 read after FD FD");
    memAccess(0, 8'hED, "R6 new instruction ED");
    turboSel = 1;
    memAccess(0, 8'hB0, "R8 turbo second byte after ED");
    memAccess(1, 8'h10, "R8 turbo plain read");
    memAccess(0, 8'h00, "R8 turbo fetch");
    turboSel = 0;

    ioWrite(8'hBF, 8'h07);
    memAccess(0, 8'h3E, "R7 mode 07 fetch");
    memAccess(1, 8'h3E, "R7 mode 07 read");
    ioWrite(8'hBF, 8'h80);
    memAccess(2, 8'h3E, "R7 mode 80 write");
    ioWrite(8'hBF, 8'h00);
    memAccess(1, 8'h3E, "R2 mode rewritten to 00");

    repeat (3) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R9: pending accesses actual=%0d expected=0", expQ.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule